// File: doc/BRIEF.md
# UART DMA Request Pacer

This block drives the two request lines that pace an external DMA engine against a UART's receive and transmit FIFOs. It watches the occupancy counts of both FIFOs and raises a receive request when data is waiting to be read, and a transmit request when there is room to write. Both request lines are active high.

A single mode bit chooses between two pacing schemes. In single-transfer mode (bit low), each request covers one character: the receive request follows "receive FIFO not empty" and the transmit request follows "transmit FIFO empty". In block mode (bit high), each request has hysteresis. The receive request starts a burst when the receive count reaches a programmable trigger level and holds until the FIFO is empty. The transmit request starts a burst when the free space in the transmit FIFO is larger than one of four thresholds chosen by a 2-bit select. It then holds until the FIFO is full. Raising the transmit request before the FIFO runs dry gives the bus arbiter time to hand the bus to the DMA engine.

Each direction is one two-state machine with the states IDLE and BURST. The IDLE to BURST transition is called START and the BURST to IDLE transition is called STOP. A change of the mode bit forces both machines to IDLE through the RESTART transition, which wins over START and STOP. The request outputs are decoded from the registered state, so they change on the clock edge that follows the FIFO count update.

Top module: `uart_dma_pacer`

## Requirements
- R1: While reset is active, and on the first clock edge after reset is released, both `rx_req` and `tx_req` are low.
- R2: With `block_mode` = 0 and the mode unchanged, `rx_req` after a clock edge equals (`rx_count` != 0) as sampled at that edge.
- R3: With `block_mode` = 0 and the mode unchanged, `tx_req` after a clock edge equals (`tx_count` == 0) as sampled at that edge. One write, which makes the count 1, drops the request on the next edge.
- R4: With `block_mode` = 1, an idle receive machine starts a burst (START) on an edge where `rx_count` >= `rx_trig` and `rx_count` != 0. `rx_req` is high after that edge.
- R5: In block mode, `rx_req` stays high while `rx_count` is non-zero, including counts below the trigger. It drops (STOP) on the edge after `rx_count` reaches 0.
- R6: In block mode, an idle transmit machine starts a burst when the free space (DEPTH − `tx_count`) is strictly greater than the threshold picked by `tx_thr_sel`. The thresholds are 0 → DEPTH/8, 1 → DEPTH/4, 2 → DEPTH/2 and 3 → 7·DEPTH/8, which for DEPTH = 64 gives 8, 16, 32 and 56.
- R7: In block mode, `tx_req` stays high until `tx_count` equals DEPTH, even when the free space falls to or below the threshold. It drops on the edge after the FIFO becomes full.
- R8: On an edge where `block_mode` differs from its value at the previous edge, both machines go to IDLE (RESTART). Both requests are low after that edge, whatever the counts are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| block_mode | input | 1 | 0 = single-transfer mode, 1 = block mode |
| rx_count | input | CW (7) | Receive FIFO occupancy, 0..DEPTH |
| tx_count | input | CW (7) | Transmit FIFO occupancy, 0..DEPTH |
| rx_trig | input | CW (7) | Receive trigger level for block mode |
| tx_thr_sel | input | 2 | Transmit free-space threshold select |
| rx_req | output | 1 | Receive DMA request |
| tx_req | output | 1 | Transmit DMA request |

## Verification
Directed sequences drive each direction in both modes. The receive count ramps up past the trigger and drains back to zero, which separates the entry condition from the hold condition and shows whether STOP fires at empty or at the trigger. The transmit FIFO drains across each of the four threshold selects, stopping exactly at and one past each threshold, which separates a strict from a non-strict comparison and exposes a wrong threshold. The FIFO is then refilled to full to show the hold. Mode flips during an active burst test RESTART. A long random walk of both counts with occasional mode flips is compared against the behavioural model on every edge.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;

    typedef enum logic {
        REQ_IDLE  = 1'b0,
        REQ_BURST = 1'b1
    } req_state_t;

endpackage

// File: rtl/tx_thr_decode.sv
module tx_thr_decode #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] thr
);
    localparam int THR0 = DEPTH / 8;
    localparam int THR1 = DEPTH / 4;
    localparam int THR2 = DEPTH / 2;
    localparam int THR3 = (DEPTH * 7) / 8;

    always_comb begin
        unique case (sel)
            2'd0: thr = CW'(THR0);
            2'd1: thr = CW'(THR1);
            2'd2: thr = CW'(THR2);
            2'd3: thr = CW'(THR3);
            default: thr = CW'(THR0);
        endcase
    end
endmodule

// File: rtl/rx_req_fsm.sv
module rx_req_fsm
    import uart_dma_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          block_mode,
    input  logic          restart,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] trig,
    output logic          req
);
    req_state_t state_q, state_d;
    logic       empty;
    logic       start_hit;

    assign empty = (count == '0);

    always_comb begin
        if (block_mode) start_hit = !empty && (count >= trig);
        else            start_hit = !empty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = REQ_IDLE;
        end else begin
            unique case (state_q)
                REQ_IDLE:  if (start_hit) state_d = REQ_BURST;
                REQ_BURST: if (empty)     state_d = REQ_IDLE;
                default:                  state_d = REQ_IDLE;
            endcase
        end
    end

    always_comb begin
        req = (state_q == REQ_BURST);
    end
endmodule

// File: rtl/tx_req_fsm.sv
module tx_req_fsm
    import uart_dma_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          block_mode,
    input  logic          restart,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] thr,
    output logic          req
);
    req_state_t    state_q, state_d;
    logic [CW-1:0] free_space;
    logic          start_hit;
    logic          stop_hit;

    assign free_space = CW'(DEPTH) - count;

    always_comb begin
        if (block_mode) begin
            start_hit = (free_space > thr);
            stop_hit  = (count == CW'(DEPTH));
        end else begin
            start_hit = (count == '0);
            stop_hit  = (count != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = REQ_IDLE;
        end else begin
            unique case (state_q)
                REQ_IDLE:  if (start_hit) state_d = REQ_BURST;
                REQ_BURST: if (stop_hit)  state_d = REQ_IDLE;
                default:                  state_d = REQ_IDLE;
            endcase
        end
    end

    always_comb begin
        req = (state_q == REQ_BURST);
    end
endmodule

// File: rtl/uart_dma_pacer.sv
module uart_dma_pacer #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          block_mode,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] rx_trig,
    input  logic [1:0]    tx_thr_sel,
    output logic          rx_req,
    output logic          tx_req
);
    logic          mode_q;
    logic          restart;
    logic [CW-1:0] tx_thr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= block_mode;
    end

    assign restart = (block_mode != mode_q);

    tx_thr_decode #(.DEPTH(DEPTH), .CW(CW)) u_thr (
        .sel (tx_thr_sel),
        .thr (tx_thr)
    );

    rx_req_fsm #(.CW(CW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .block_mode (block_mode),
        .restart    (restart),
        .count      (rx_count),
        .trig       (rx_trig),
        .req        (rx_req)
    );

    tx_req_fsm #(.DEPTH(DEPTH), .CW(CW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .block_mode (block_mode),
        .restart    (restart),
        .count      (tx_count),
        .thr        (tx_thr),
        .req        (tx_req)
    );
endmodule

// File: rtl/uart_dma_pacer_chk.sv
module uart_dma_pacer_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          block_mode,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_trig,
    input logic          rx_req,
    input logic          tx_req
);
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    always_comb begin
        if (!rst_n) begin
            a_r1_reset_low: assert (!rx_req && !tx_req);
        end
    end

    a_r1_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (!rx_req && !tx_req));

    a_r2_single_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !block_mode && $stable(block_mode)) |=> (rx_req == $past(rx_count != '0)));

    a_r3_single_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !block_mode && $stable(block_mode)) |=> (tx_req == $past(tx_count == '0)));

    a_r4_rx_start: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && block_mode && $stable(block_mode) && rx_count != '0 && rx_count >= rx_trig)
        |=> rx_req);

    a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && block_mode && $stable(block_mode) && rx_req && rx_count != '0) |=> rx_req);

    a_r5_rx_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && block_mode && rx_count == '0) |=> !rx_req);

    a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && block_mode && $stable(block_mode) && tx_req && tx_count != CW'(DEPTH)) |=> tx_req);

    a_r7_tx_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && block_mode && tx_count == CW'(DEPTH)) |=> !tx_req);

    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$stable(block_mode)) |=> (!rx_req && !tx_req));
endmodule

bind uart_dma_pacer uart_dma_pacer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .block_mode (block_mode),
    .rx_count   (rx_count),
    .tx_count   (tx_count),
    .rx_trig    (rx_trig),
    .rx_req     (rx_req),
    .tx_req     (tx_req)
);

// File: tb/uart_dma_pacer_tb.sv
`timescale 1ns/1ps
module uart_dma_pacer_tb;
    localparam int DEPTH = 64;
    localparam int CW    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          block_mode = 1'b0;
    logic [CW-1:0] rx_count = '0;
    logic [CW-1:0] tx_count = '0;
    logic [CW-1:0] rx_trig = CW'(1);
    logic [1:0]    tx_thr_sel = 2'd0;
    logic          rx_req, tx_req;

    int checks = 0;
    int fails  = 0;

    int m_rx = 0, m_tx = 0, m_prev_mode = 0;

    always #4 clk = ~clk;

    uart_dma_pacer #(.DEPTH(DEPTH), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .block_mode(block_mode),
        .rx_count(rx_count), .tx_count(tx_count), .rx_trig(rx_trig),
        .tx_thr_sel(tx_thr_sel), .rx_req(rx_req), .tx_req(tx_req)
    );

    function automatic int thr_of(int sel);
        int t[4] = '{8, 16, 32, 56};
        return t[sel];
    endfunction

    task automatic model_edge();
        int rc = int'(rx_count);
        int tc = int'(tx_count);
        int md = int'(block_mode);
        if (md != m_prev_mode) begin
            m_rx = 0; m_tx = 0;
        end else if (md == 0) begin
            m_rx = (rc != 0);
            m_tx = (tc == 0);
        end else begin
            if (m_rx == 0 && rc != 0 && rc >= int'(rx_trig)) m_rx = 1;
            else if (m_rx == 1 && rc == 0)                  m_rx = 0;
            if (m_tx == 0 && (DEPTH - tc) > thr_of(int'(tx_thr_sel))) m_tx = 1;
            else if (m_tx == 1 && tc == DEPTH)                          m_tx = 0;
        end
        m_prev_mode = md;
    endtask

    task automatic check(string tag_rx, string tag_tx);
        checks++;
        if (rx_req !== m_rx[0]) begin
            fails++;
            $display("FAIL %s rx_req actual=%b expected=%0d t=%0t", tag_rx, rx_req, m_rx, $time);
        end
        checks++;
        if (tx_req !== m_tx[0]) begin
            fails++;
            $display("FAIL %s tx_req actual=%b expected=%0d t=%0t", tag_tx, tx_req, m_tx, $time);
        end
    endtask

    // Drive inputs at negedge, advance one edge, update model, compare after edge.
    task automatic step(int md, int rc, int tc, string tag_rx, string tag_tx);
        @(negedge clk);
        block_mode = md[0];
        rx_count   = CW'(rc);
        tx_count   = CW'(tc);
        @(posedge clk);
        model_edge();
        #1;
        check(tag_rx, tag_tx);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        #20;
        check("R1", "R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        model_edge();
        #1;
        check("R1", "R1");

        // R2 / R3: single-transfer mode
        step(0, 0, 5, "R2", "R3");
        step(0, 1, 5, "R2", "R3");
        step(0, 1, 0, "R2", "R3");
        step(0, 0, 1, "R2", "R3");   // one write drops tx_req
        step(0, 3, 0, "R2", "R3");
        step(0, 0, 0, "R2", "R3");

        // R4 / R5: block mode receive, trigger 16
        rx_trig = CW'(16);
        step(1, 0, DEPTH, "R8", "R8");
        for (int i = 1; i <= 16; i++) step(1, i, DEPTH, "R4", "R7");
        for (int i = 15; i >= 0; i--) step(1, i, DEPTH, "R5", "R7");
        step(1, 15, DEPTH, "R4", "R7");   // below trigger after STOP: stays idle

        // R6 / R7: transmit thresholds, all four selects
        for (int s = 0; s < 4; s++) begin
            tx_thr_sel = 2'(s);
            for (int c = DEPTH; c >= DEPTH - thr_of(s) - 1; c--) step(1, 0, c, "R5", "R6");
            for (int c = DEPTH - thr_of(s); c <= DEPTH; c++) step(1, 0, c, "R5", "R7");
            step(1, 0, DEPTH - 1, "R5", "R7");
        end

        // R8: mode flip during active bursts
        tx_thr_sel = 2'd0;
        step(1, 20, 10, "R4", "R6");
        step(1, 20, 10, "R4", "R6");
        step(0, 20, 10, "R8", "R8");
        step(0, 20, 10, "R2", "R3");
        step(1, 20, 0, "R8", "R8");
        step(1, 20, 0, "R4", "R6");

        // Random walk against the model
        for (int n = 0; n < 4000; n++) begin
            int md = int'(block_mode);
            int rc = int'(rx_count);
            int tc = int'(tx_count);
            if ($urandom % 150 == 0) md = 1 - md;
            if ($urandom % 300 == 0) rx_trig = CW'(1 + $urandom % DEPTH);
            if ($urandom % 300 == 0) tx_thr_sel = 2'($urandom % 4);
            rc = rc + int'($urandom % 3) - 1;
            tc = tc + int'($urandom % 3) - 1;
            if ($urandom % 100 == 0) rc = 0;
            if ($urandom % 100 == 0) tc = DEPTH;
            if (rc < 0) rc = 0;
            if (rc > DEPTH) rc = DEPTH;
            if (tc < 0) tc = 0;
            if (tc > DEPTH) tc = DEPTH;
            step(md, rc, tc, md ? "R5" : "R2", md ? "R7" : "R3");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule